// File: doc/BRIEF.md
# Dual-Reference Clock Failover Supervisor

This block supervises the two reference clocks of a clock generator. Software programs it through nine byte-wide registers on a simple parallel bus: write strobe, address, write data, and combinational read data. From those settings and from per-reference failure flags supplied by external loss detectors, it picks which reference feeds the PLL. It also switches to the other reference on a failure and, if allowed, returns to the preferred one. When no usable reference is left, or when software asks for it, it enters holdover.

The block also latches the oscillator frequency word as a nominal value when software requests it. It produces per-output drive controls, the select for the third output's divider source, an interrupt, and a chip-wide reset request. The detectors, the PLL and the dividers are outside the block and appear only as flags and words on its ports.

Top module: `ckfo_top`

## Requirements
- R1: After reset, address 5 reads 0x60 and addresses 0–4, 6, 7 and 8 read 0x00. Addresses 9–15 always read 0x00.
- R2: In the address-5 byte, bit 6 enables output 0 (`out_oe[0]`) and bit 5 enables output 1 (`out_oe[1]`). Bit 7 drives `out_force_low[n]` high only for an enabled output, so a disabled output stays high-impedance whatever bit 7 holds.
- R3: Bits 3:2 of address 5 choose the usable references. 01 allows only reference 0 and 10 allows only reference 1. 11 allows both. 00 takes the mask from `pin_pick`, where bit n allows reference n and the value 00 allows both.
- R4: If the active reference is unusable and the other is usable, `ref_sel` changes at the next clock edge. On that edge, status bit 7 (sticky alarm) and `irq` are set.
- R5: With bit 1 of address 5 at 0 (nonrevertive), the block stays on the alternate reference after the failed one recovers.
- R6: With bit 1 of address 5 at 1 (revertive), the block returns to the preferred reference given by bit 4 of address 5 one clock after that reference is usable.
- R7: A write to address 5 with bits 1 and 0 both set selects the preferred reference and clears the alarm and `irq`. With bit 1 clear, bit 0 has no effect. Bit 0 always reads 0.
- R8: With bit 7 of address 6 set, `holdover` is high while no usable reference exists and falls when one returns.
- R9: `holdover` is high while bit 6 of address 6 is 1. A 0-to-1 write of bit 6 or of bit 5 of address 6 copies `vcxo_word` into `nominal_word`, and a write that keeps either bit at 1 copies nothing. Bit 1 of address 6 drives `xtal_use_nominal`.
- R10: Writing bit 4 of address 6 as 1 raises `chip_reset` for one cycle and then returns all registers to their reset values, as asserting `ext_rst_req` does.
- R11: Address 7 reads {alarm, ref0 failed, ref1 failed, `ref_sel`, `pll_unlock`, `holdover`, 0, 0} from bit 7 down and ignores writes. Bits 4, 3 and 0 of address 6 read 0, and bit 2 drives `clk2_div_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst_req | input | 1 | External chip reset request, synchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ref_fail | input | 2 | Per-reference failure flag from the loss detectors |
| pin_pick | input | 2 | Reference-allow pins used when bits 3:2 of address 5 are 00 |
| pll_unlock | input | 1 | PLL not locked |
| vcxo_word | input | VCXO_W | Current oscillator frequency word |
| ref_sel | output | 1 | Reference fed to the PLL |
| irq | output | 1 | Interrupt, follows the sticky alarm |
| holdover | output | 1 | Holdover active |
| out_oe | output | 2 | Per-output drive enable (0 = high impedance) |
| out_force_low | output | 2 | Per-output force-low |
| clk2_div_sel | output | 1 | Divider source for the third output |
| xtal_use_nominal | output | 1 | Crystal steered by the latched nominal word |
| nominal_word | output | VCXO_W | Latched nominal frequency word |
| chip_reset | output | 1 | Chip-wide reset request |

## Verification
A table walks the failure flags through a sequence with both references allowed and nonrevertive policy. The steps are: healthy, reference 0 lost, recovery, reference 1 lost, both lost, and recovery. This separates a real failover from a return to the preferred reference, and shows that the selection holds when neither reference is usable. The same loss and recovery is then repeated under revertive policy, so that R5 and R6 produce different `ref_sel` values for identical inputs. Pin-driven and single-reference masks are then checked to confirm that an unusable alternate blocks failover and leads to holdover.

// File: rtl/ckfo_pkg.sv
package ckfo_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int DIV_REGS  = 5;
    localparam int NUM_REFS  = 2;
    localparam int NUM_OUTS  = 2;

    localparam logic [ADDR_W-1:0] A_OUTCFG = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] A_HOLD   = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] A_SPARE  = ADDR_W'(8);

    typedef enum logic [1:0] {
        EN_PINS  = 2'b00,
        EN_ONLY0 = 2'b01,
        EN_ONLY1 = 2'b10,
        EN_BOTH  = 2'b11
    } en_mode_e;

    typedef struct packed {
        logic     out_low;
        logic     oe0;
        logic     oe1;
        logic     dflt;
        en_mode_e mode;
        logic     revert;
        logic     clr_act;
    } outcfg_t;

    typedef struct packed {
        logic hold_en;
        logic hold_force;
        logic grab;
        logic soft_rst;
        logic zero3;
        logic div_sel;
        logic use_nom;
        logic rsv;
    } holdcfg_t;

    localparam outcfg_t OUTCFG_RST = outcfg_t'(8'h60);
    localparam logic [DATA_W-1:0] OUTCFG_KEEP = 8'hFE;
    localparam logic [DATA_W-1:0] HOLD_KEEP   = 8'hE6;

    function automatic logic [NUM_REFS-1:0] enable_mask(en_mode_e m, logic [NUM_REFS-1:0] pins);
        logic [NUM_REFS-1:0] r;
        if (m == EN_PINS) r = (pins == '0) ? '1 : pins;
        else              r = m;
        return r;
    endfunction

endpackage

// File: rtl/ckfo_regs.sv
module ckfo_regs
    import ckfo_pkg::*;
#(
    parameter int VCXO_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  status_byte,
    input  logic [VCXO_W-1:0]  vcxo_word,
    output logic [DATA_W-1:0]  rdata,
    output outcfg_t            outcfg,
    output holdcfg_t           holdcfg,
    output logic [VCXO_W-1:0]  nominal,
    output logic               monitor_clr,
    output logic               soft_pulse
);

    logic [DATA_W-1:0] div_q [DIV_REGS];
    logic [DATA_W-1:0] spare_q;
    outcfg_t           oc_q;
    holdcfg_t          hc_q;
    logic [VCXO_W-1:0] nom_q;
    logic              soft_q;
    logic              any_rst, hit5, hit6, capture;

    assign any_rst     = rst | ext_rst | soft_q;
    assign hit5        = wr_en && (addr == A_OUTCFG) && !any_rst;
    assign hit6        = wr_en && (addr == A_HOLD) && !any_rst;
    assign capture     = hit6 && ((wdata[6] && !hc_q.hold_force) || (wdata[5] && !hc_q.grab));
    assign monitor_clr = hit5 && wdata[1] && wdata[0];

    always_ff @(posedge clk) begin
        if (rst || ext_rst) soft_q <= 1'b0;
        else                soft_q <= hit6 && wdata[4];
    end

    always_ff @(posedge clk) begin
        if (any_rst) begin
            for (int i = 0; i < DIV_REGS; i++) div_q[i] <= '0;
            spare_q <= '0;
            oc_q    <= OUTCFG_RST;
            hc_q    <= '0;
            nom_q   <= '0;
        end else begin
            if (wr_en) begin
                for (int i = 0; i < DIV_REGS; i++)
                    if (addr == ADDR_W'(i)) div_q[i] <= wdata;
                if (addr == A_OUTCFG) oc_q    <= outcfg_t'(wdata & OUTCFG_KEEP);
                if (addr == A_HOLD)   hc_q    <= holdcfg_t'(wdata & HOLD_KEEP);
                if (addr == A_SPARE)  spare_q <= wdata;
            end
            if (capture) nom_q <= vcxo_word;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DIV_REGS; i++)
            if (addr == ADDR_W'(i)) rdata = div_q[i];
        case (addr)
            A_OUTCFG: rdata = oc_q;
            A_HOLD:   rdata = hc_q;
            A_STATUS: rdata = status_byte;
            A_SPARE:  rdata = spare_q;
            default:  ;
        endcase
    end

    assign outcfg     = oc_q;
    assign holdcfg    = hc_q;
    assign nominal    = nom_q;
    assign soft_pulse = soft_q;

    // R10: a soft reset pulse restores the output configuration default
    p_soft_reset_r10: assert property (@(posedge clk) disable iff (rst || ext_rst)
        soft_q |=> (oc_q == OUTCFG_RST && hc_q == '0));

    // R9: the nominal word moves only on a capture request
    p_nominal_hold_r9: assert property (@(posedge clk) disable iff (rst || ext_rst)
        (!capture && !soft_q) |=> $stable(nom_q));

endmodule

// File: rtl/ckfo_select.sv
module ckfo_select
    import ckfo_pkg::*;
(
    input  logic                clk,
    input  logic                rst_any,
    input  logic [NUM_REFS-1:0] en_mask,
    input  logic [NUM_REFS-1:0] ref_fail,
    input  logic                dflt,
    input  logic                revert,
    input  logic                clr,
    output logic                act,
    output logic                alarm,
    output logic [NUM_REFS-1:0] healthy
);

    logic other;

    assign healthy = en_mask & ~ref_fail;
    assign other   = ~act;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            act   <= 1'b0;
            alarm <= 1'b0;
        end else if (clr) begin
            act   <= dflt;
            alarm <= 1'b0;
        end else if (!healthy[act] && healthy[other]) begin
            act   <= other;
            alarm <= 1'b1;
        end else if (revert && (act != dflt) && healthy[dflt]) begin
            act   <= dflt;
        end
    end

    // R4: an unusable active reference with a usable partner is left at the next edge
    p_failover_r4: assert property (@(posedge clk) disable iff (rst_any)
        (!clr && !healthy[act] && healthy[other]) |=> (act != $past(act)));

    // R4: the alarm stays set until cleared
    p_alarm_sticky_r4: assert property (@(posedge clk) disable iff (rst_any)
        (alarm && !clr) |=> alarm);

    // R5: nonrevertive selection holds while the active reference is usable
    p_nonrevert_hold_r5: assert property (@(posedge clk) disable iff (rst_any)
        (!revert && !clr && healthy[act]) |=> $stable(act));

    // R6: revertive selection lands on the usable preferred reference
    p_revert_r6: assert property (@(posedge clk) disable iff (rst_any)
        (revert && healthy[dflt]) |=> (act == $past(dflt)));

endmodule

// File: rtl/ckfo_top.sv
module ckfo_top
    import ckfo_pkg::*;
#(
    parameter int VCXO_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ext_rst_req,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [1:0]          ref_fail,
    input  logic [1:0]          pin_pick,
    input  logic                pll_unlock,
    input  logic [VCXO_W-1:0]   vcxo_word,
    output logic                ref_sel,
    output logic                irq,
    output logic                holdover,
    output logic [1:0]          out_oe,
    output logic [1:0]          out_force_low,
    output logic                clk2_div_sel,
    output logic                xtal_use_nominal,
    output logic [VCXO_W-1:0]   nominal_word,
    output logic                chip_reset
);

    outcfg_t             oc;
    holdcfg_t            hc;
    logic                clr, soft_pulse, alarm, rst_any;
    logic [NUM_REFS-1:0] healthy, en_mask;
    logic [DATA_W-1:0]   status_byte;
    logic [NUM_OUTS-1:0] oe_bits;

    assign rst_any     = rst | ext_rst_req | soft_pulse;
    assign en_mask     = enable_mask(oc.mode, pin_pick);
    assign holdover    = hc.hold_force | (hc.hold_en & ~|healthy);
    assign status_byte = {alarm, ref_fail[0], ref_fail[1], ref_sel, pll_unlock, holdover, 2'b00};

    ckfo_regs #(.VCXO_W(VCXO_W)) u_regs (
        .clk(clk), .rst(rst), .ext_rst(ext_rst_req),
        .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .status_byte(status_byte), .vcxo_word(vcxo_word),
        .rdata(bus_rdata), .outcfg(oc), .holdcfg(hc),
        .nominal(nominal_word), .monitor_clr(clr), .soft_pulse(soft_pulse)
    );

    ckfo_select u_sel (
        .clk(clk), .rst_any(rst_any), .en_mask(en_mask), .ref_fail(ref_fail),
        .dflt(oc.dflt), .revert(oc.revert), .clr(clr),
        .act(ref_sel), .alarm(alarm), .healthy(healthy)
    );

    assign oe_bits = {oc.oe1, oc.oe0};

    generate
        for (genvar g = 0; g < NUM_OUTS; g++) begin : g_out
            assign out_oe[g]        = oe_bits[g];
            assign out_force_low[g] = oc.out_low & oe_bits[g];
        end
    endgenerate

    assign irq              = alarm;
    assign clk2_div_sel     = hc.div_sel;
    assign xtal_use_nominal = hc.use_nom;
    assign chip_reset       = ext_rst_req | soft_pulse;

    // R8: automatic holdover only when nothing usable remains
    p_hold_auto_r8: assert property (@(posedge clk) disable iff (rst_any)
        (holdover && !hc.hold_force) |-> (healthy == '0));

endmodule

// File: tb/tb_ckfo_top.sv
module tb_ckfo_top;
    localparam int VW = 12;

    logic clk = 1'b0;
    logic rst, ext_rst_req, bus_wr, pll_unlock;
    logic [3:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [1:0] ref_fail, pin_pick, out_oe, out_force_low;
    logic [VW-1:0] vcxo_word, nominal_word;
    logic ref_sel, irq, holdover, clk2_div_sel, xtal_use_nominal, chip_reset;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ckfo_top #(.VCXO_W(VW)) dut (.*);

    // {ref_fail[1:0], expected ref_sel}
    localparam logic [2:0] VEC [6] = '{3'b000, 3'b011, 3'b001, 3'b100, 3'b110, 3'b000};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic step(input logic [1:0] f);
        ref_fail = f;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ext_rst_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        ref_fail = '0; pin_pick = '0; pll_unlock = 1'b0; vcxo_word = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 16; a++)
            rd_chk("R1 reset read", 4'(a), (a == 5) ? 8'h60 : 8'h00);
        chk("R1 ref_sel", ref_sel, 0);
        chk("R2 reset oe", out_oe, 2'b11);

        // R4/R5 vector walk: both allowed, nonrevertive, preferred 0
        wr(4'd5, 8'h6C);
        foreach (VEC[i]) begin
            step(VEC[i][2:1]);
            chk("R4 R5 vector sel", ref_sel, VEC[i][0]);
        end
        chk("R4 irq sticky", irq, 1);

        // R7 clear ignored without revertive bit
        wr(4'd5, 8'h6D);
        chk("R7 no clear nonrevert", irq, 1);
        rd_chk("R7 bit0 reads 0", 4'd5, 8'h6C);

        // R6 revertive
        wr(4'd5, 8'h6E);
        wr(4'd5, 8'h6F);
        chk("R7 clear irq", irq, 0);
        step(2'b01);
        chk("R4 failover", ref_sel, 1);
        chk("R4 irq set", irq, 1);
        step(2'b00);
        chk("R6 revert", ref_sel, 0);
        pll_unlock = 1'b1;
        rd_chk("R11 status", 4'd7, 8'h88);
        pll_unlock = 1'b0;
        wr(4'd7, 8'hFF);
        rd_chk("R11 status write ignored", 4'd7, 8'h80);
        wr(4'd5, 8'h6F);
        chk("R7 clear", irq, 0);

        // R3 pin mode with only ref0 allowed, R8 holdover
        wr(4'd6, 8'h80);
        wr(4'd5, 8'h60);
        pin_pick = 2'b01;
        step(2'b01);
        chk("R3 no failover to disallowed", ref_sel, 0);
        chk("R8 auto holdover", holdover, 1);
        rd_chk("R11 status hold", 4'd7, 8'h44);
        step(2'b00);
        chk("R8 holdover exit", holdover, 0);
        pin_pick = 2'b00;
        step(2'b01);
        chk("R3 pins 00 allows both", ref_sel, 1);
        step(2'b00);
        wr(4'd5, 8'h64);
        step(2'b10);
        chk("R3 only ref0 field", ref_sel, 0);
        step(2'b00);

        // R9 forced holdover and capture
        vcxo_word = 12'h5A3;
        wr(4'd6, 8'hC0);
        chk("R9 capture on rise", nominal_word, 12'h5A3);
        chk("R9 forced holdover", holdover, 1);
        vcxo_word = 12'h111;
        wr(4'd6, 8'hC0);
        chk("R9 no capture when held", nominal_word, 12'h5A3);
        wr(4'd6, 8'h80);
        chk("R9 forced off", holdover, 0);
        wr(4'd6, 8'hA2);
        chk("R9 grab bit capture", nominal_word, 12'h111);
        chk("R9 use nominal", xtal_use_nominal, 1);
        wr(4'd6, 8'hAE);
        rd_chk("R11 addr6 readback", 4'd6, 8'hA6);
        chk("R11 div select", clk2_div_sel, 1);

        // R2 output controls
        wr(4'd5, 8'hE0);
        chk("R2 force low both", out_force_low, 2'b11);
        wr(4'd5, 8'hA0);
        chk("R2 oe", out_oe, 2'b10);
        chk("R2 hiz overrides low", out_force_low, 2'b10);

        // R10 soft reset
        wr(4'd0, 8'h33);
        wr(4'd6, 8'h10);
        chk("R10 chip_reset pulse", chip_reset, 1);
        @(negedge clk);
        chk("R10 chip_reset ends", chip_reset, 0);
        rd_chk("R10 addr5 restored", 4'd5, 8'h60);
        rd_chk("R10 addr0 restored", 4'd0, 8'h00);
        chk("R10 nominal restored", nominal_word, 0);

        // R10 external reset
        wr(4'd5, 8'h00);
        ext_rst_req = 1'b1;
        #1;
        chk("R10 ext chip_reset", chip_reset, 1);
        @(negedge clk);
        ext_rst_req = 1'b0;
        rd_chk("R10 ext restores", 4'd5, 8'h60);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule